// File: doc/BRIEF.md
# SMBus Master Clock Generator

This block produces the SCL clock for an SMBus master. It does not divide the system clock itself. It is paced by overflow pulses from one of four timer sources, and a two-bit select field chooses which source. The SCL low phase lasts at least two overflow periods with the line driven low. The high phase lasts at least one overflow period with the line released. A typical bit therefore takes three overflow periods, and the bit rate is never faster than the limit those minimum times set.

After releasing SCL, the block counts nothing until the sampled line actually reads high. A slave can therefore stretch the clock for as long as it needs. If the line is pulled low during the high phase, the block treats that as the end of the high phase and starts a new low phase. A byte engine placed above the block receives one-cycle strobes at each rising and falling bit edge. When the run request is dropped, the block finishes the bit in progress and leaves SCL released.

Top module: `smb_scl_gen`

## Requirements
- R1: While `rst_ni` is low, and right after it goes high, `scl_drive_low_o`, `rise_stb_o` and `fall_stb_o` are all 0. Reset acts asynchronously.
- R2: `src_sel_i` selects one bit of `tick_i`: 0 selects bit 0 (timer 0 overflow), 1 selects bit 1 (timer 1 overflow), 2 selects bit 2 (timer 2 high-byte overflow) and 3 selects bit 3 (timer 2 low-byte overflow). Pulses on the other three bits do not advance any phase.
- R3: While `en_i` is 0, SCL is released and no strobe is issued, whatever `run_i`, `scl_i` or the ticks do. This takes effect from the clock edge after `en_i` is sampled low.
- R4: When the block is enabled and idle and `run_i` is 1, `scl_drive_low_o` and `fall_stb_o` go to 1 after the next clock edge.
- R5: The low phase ends at the edge that samples the second selected tick counted in that phase. SCL is released after that edge.
- R6: After SCL is released, ticks are ignored until `scl_i` is sampled high. The edge that samples it high starts the high phase, and `rise_stb_o` is 1 for the following cycle.
- R7: The high phase ends at the edge that samples one selected tick. If `run_i` is 1, SCL is driven low again and `fall_stb_o` pulses.
- R8: If `scl_i` is sampled low during the high phase, the block drives SCL low at the next edge, pulses `fall_stb_o` and starts a new low phase.
- R9: With `run_i` at 0, the bit in progress runs through its low and high phases. After the high phase, SCL stays released and no further falling strobe is issued.
- R10: Each strobe lasts one cycle. `rise_stb_o` and `fall_stb_o` are never high together.
- R11: While the block is idle, ticks produce no strobe and do not drive SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| src_sel_i | input | 2 | Tick source select |
| tick_i | input | 4 | Timer overflow pulses, one per source |
| scl_i | input | 1 | Sampled SCL level (already synchronized) |
| run_i | input | 1 | Request to generate clock bits |
| scl_drive_low_o | output | 1 | 1 = pull SCL low |
| rise_stb_o | output | 1 | One-cycle pulse when the high phase starts |
| fall_stb_o | output | 1 | One-cycle pulse when SCL is driven low |

## Verification
An error in the phase state or the tick count reaches `scl_drive_low_o` within one clock edge. A count that is off by one releases SCL one tick too early or too late. A wrong source index lets a foreign tick end a phase. A state that skips the wait for a high line shows up as `rise_stb_o` firing while `scl_i` is still low. Each of these faults shows on the pins in the cycle after the offending edge, so checks are sampled one cycle after every stimulus edge.

// File: rtl/smb_scl_pkg.sv
package smb_scl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_state_e;
endpackage

// File: rtl/smb_tick_sel.sv
module smb_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_SRC-1:0] tick_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = active_i && (|hit);
endmodule

// File: rtl/smb_phase_cnt.sv
module smb_phase_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = inc_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/smb_scl_gen.sv
module smb_scl_gen
  import smb_scl_pkg::*;
#(
  parameter int N_SRC      = 4,
  parameter int LOW_TICKS  = 2,
  parameter int HIGH_TICKS = 1,
  localparam int SEL_W = $clog2(N_SRC),
  localparam int MAX_T = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS,
  localparam int CNT_W = $clog2(MAX_T + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [N_SRC-1:0] tick_i,
  input  logic             scl_i,
  input  logic             run_i,
  output logic             scl_drive_low_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);
  scl_state_e       state_q, state_d;
  logic             sel_tick, counting, phase_done;
  logic [CNT_W-1:0] limit;
  logic             rise_q, fall_q;

  smb_tick_sel #(.N_SRC(N_SRC)) u_sel (
    .active_i (en_i && (state_q != ST_IDLE)),
    .sel_i    (src_sel_i),
    .tick_i   (tick_i),
    .tick_o   (sel_tick)
  );

  assign counting = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign limit    = (state_q == ST_LOW) ? CNT_W'(LOW_TICKS) : CNT_W'(HIGH_TICKS);

  smb_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_d != state_q),
    .inc_i   (sel_tick && counting),
    .limit_i (limit),
    .done_o  (phase_done)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (run_i)      state_d = ST_LOW;
        ST_LOW:  if (phase_done) state_d = ST_WAIT;
        ST_WAIT: if (scl_i)      state_d = ST_HIGH;
        ST_HIGH: begin
          // line pulled low by another device ends the high phase
          if (!scl_i)          state_d = ST_LOW;
          else if (phase_done) state_d = run_i ? ST_LOW : ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rise_q  <= (state_d == ST_HIGH) && (state_q != ST_HIGH);
      fall_q  <= (state_d == ST_LOW) && (state_q != ST_LOW);
    end
  end

  assign scl_drive_low_o = (state_q == ST_LOW);
  assign rise_stb_o      = rise_q;
  assign fall_stb_o      = fall_q;
endmodule

// File: rtl/smb_scl_gen_chk.sv
module smb_scl_gen_chk #(
  parameter int N_SRC     = 4,
  parameter int LOW_TICKS = 2,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [SEL_W-1:0] src_sel_i,
  input logic [N_SRC-1:0] tick_i,
  input logic             scl_i,
  input logic             scl_drive_low_o,
  input logic             rise_stb_o,
  input logic             fall_stb_o
);
  logic [3:0] lo_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     lo_ticks <= '0;
    else if (!scl_drive_low_o)                       lo_ticks <= '0;
    else if (tick_i[src_sel_i] && lo_ticks < 4'd15)  lo_ticks <= lo_ticks + 1'b1;
  end

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_stb_o && fall_stb_o));

  p_rise_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |=> !rise_stb_o);

  p_fall_drives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |-> scl_drive_low_o);

  p_drive_flagged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_low_o) |-> fall_stb_o);

  p_rise_seen_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_stb_o |-> (!scl_drive_low_o && $past(scl_i)));

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_drive_low_o && !rise_stb_o && !fall_stb_o));

  p_low_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_drive_low_o) && $past(en_i)) |-> (lo_ticks >= 4'(LOW_TICKS)));
endmodule

bind smb_scl_gen smb_scl_gen_chk #(.N_SRC(N_SRC), .LOW_TICKS(LOW_TICKS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .src_sel_i       (src_sel_i),
  .tick_i          (tick_i),
  .scl_i           (scl_i),
  .scl_drive_low_o (scl_drive_low_o),
  .rise_stb_o      (rise_stb_o),
  .fall_stb_o      (fall_stb_o)
);

// File: tb/smb_scl_gen_tb.sv
module smb_scl_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] src_sel_i = 2'd0;
  logic [3:0] tick_i = 4'd0;
  logic       scl_i = 1'b1;
  logic       run_i = 1'b0;
  logic       scl_drive_low_o, rise_stb_o, fall_stb_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  smb_scl_gen dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i), .src_sel_i (src_sel_i),
    .tick_i (tick_i), .scl_i (scl_i), .run_i (run_i),
    .scl_drive_low_o (scl_drive_low_o), .rise_stb_o (rise_stb_o), .fall_stb_o (fall_stb_o)
  );

  // {en, run, sel[1:0], tick[3:0], scl, exp_drive, exp_rise, exp_fall}
  localparam int NV = 25;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0,1'b1,2'd1,4'b0010,1'b1,3'b000}, // R3 disabled
    {1'b1,1'b1,2'd1,4'b0000,1'b0,3'b101}, // R4 start
    {1'b1,1'b1,2'd1,4'b1101,1'b0,3'b100}, // R2 foreign ticks
    {1'b1,1'b1,2'd1,4'b0010,1'b0,3'b100}, // R5 first tick
    {1'b1,1'b1,2'd1,4'b0000,1'b0,3'b100}, // R5
    {1'b1,1'b1,2'd1,4'b0010,1'b0,3'b000}, // R5 second tick releases
    {1'b1,1'b1,2'd1,4'b0010,1'b0,3'b000}, // R6 stretched, tick ignored
    {1'b1,1'b1,2'd1,4'b0000,1'b1,3'b010}, // R6 seen high
    {1'b1,1'b1,2'd1,4'b0000,1'b1,3'b000}, // R10 one-cycle rise
    {1'b1,1'b1,2'd1,4'b0010,1'b1,3'b101}, // R7 high done
    {1'b1,1'b1,2'd1,4'b0010,1'b0,3'b100}, // R5
    {1'b1,1'b1,2'd1,4'b0010,1'b0,3'b000}, // R5
    {1'b1,1'b1,2'd1,4'b0000,1'b1,3'b010}, // R6
    {1'b1,1'b1,2'd1,4'b0000,1'b0,3'b101}, // R8 contention
    {1'b1,1'b0,2'd1,4'b0010,1'b0,3'b100}, // R9 run dropped
    {1'b1,1'b0,2'd1,4'b0010,1'b0,3'b000}, // R9
    {1'b1,1'b0,2'd1,4'b0000,1'b1,3'b010}, // R9
    {1'b1,1'b0,2'd1,4'b0010,1'b1,3'b000}, // R9 ends released
    {1'b1,1'b0,2'd1,4'b0010,1'b1,3'b000}, // R11 idle ticks
    {1'b1,1'b1,2'd3,4'b0000,1'b0,3'b101}, // R4
    {1'b1,1'b1,2'd3,4'b0111,1'b0,3'b100}, // R2 sel 3 ignores bits 2..0
    {1'b1,1'b1,2'd3,4'b1000,1'b0,3'b100}, // R2
    {1'b1,1'b1,2'd3,4'b1000,1'b0,3'b000}, // R2
    {1'b0,1'b1,2'd3,4'b0000,1'b1,3'b000}, // R3
    {1'b0,1'b1,2'd3,4'b1111,1'b1,3'b000}  // R3
  };
  localparam int VREQ [NV] = '{3,4,2,5,5,5,6,6,10,7,5,5,6,8,9,9,9,9,11,4,2,2,2,3,3};

  task automatic check3(input int req, input logic [2:0] exp, input string what);
    checks++;
    if ({scl_drive_low_o, rise_stb_o, fall_stb_o} !== exp) begin
      errors++;
      $display("FAIL R%0d %s: drive/rise/fall actual %b expected %b", req, what,
               {scl_drive_low_o, rise_stb_o, fall_stb_o}, exp);
    end
  endtask

  task automatic step(input logic e, input logic r, input logic [1:0] s,
                      input logic [3:0] t, input logic sc);
    en_i = e; run_i = r; src_sel_i = s; tick_i = t; scl_i = sc;
    @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check3(1, 3'b000, "in reset"); // R1
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check3(1, 3'b000, "after reset"); // R1

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9:8], VEC[i][7:4], VEC[i][3]);
      check3(VREQ[i], VEC[i][2:0], $sformatf("vector %0d", i));
    end

    // R2: source 2 (bit 2)
    step(1'b1, 1'b1, 2'd2, 4'b0000, 1'b0);
    check3(4, 3'b101, "sel2 start");
    step(1'b1, 1'b1, 2'd2, 4'b1011, 1'b0);
    check3(2, 3'b100, "sel2 foreign");
    step(1'b1, 1'b1, 2'd2, 4'b0100, 1'b0);
    step(1'b1, 1'b1, 2'd2, 4'b0100, 1'b0);
    check3(2, 3'b000, "sel2 released");
    step(1'b1, 1'b0, 2'd2, 4'b0000, 1'b1);
    check3(6, 3'b010, "sel2 rise");
    step(1'b1, 1'b0, 2'd2, 4'b0100, 1'b1);
    check3(9, 3'b000, "sel2 stop");
    step(1'b1, 1'b0, 2'd2, 4'b0000, 1'b1);
    check3(10, 3'b000, "no stray strobe");

    // R1: asynchronous reset during low phase
    step(1'b1, 1'b1, 2'd0, 4'b0000, 1'b0);
    check3(4, 3'b101, "start before reset");
    rst_ni = 1'b0;
    #2;
    check3(1, 3'b000, "async reset");
    rst_ni = 1'b1;
    en_i = 1'b0;
    @(posedge clk_i);
    #1;
    finished = 1'b1;
    finish_run();
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end
endmodule